// File: doc/BRIEF.md
# BCD Calendar Counter with Century Flag

This block keeps wall-clock time and calendar date as packed BCD fields: seconds, minutes, hours in 24-hour form, day of week, day of month, month and a two-digit year. It also keeps a century flag that can be told to flip whenever the year wraps. A one-cycle pulse on `tick` means one second has elapsed. The block then advances the seconds field, and any carries run through to the higher fields within that same clock cycle.

All fields live in a single 56-bit vector. Software, or a bus bridge outside this block, writes that vector in one cycle through `load`, and reads it back at all times on `time_q`. The top bit of the seconds byte is a halt flag. While it is set, ticks are ignored and the calendar stays frozen. Month lengths and leap years are worked out directly on the BCD digits. The leap test is only "year divisible by four", which is right for every year up to 2099.

Top module: `cal_bcd_clock`

## Requirements
- R1: While `rst_n` is low at a clock edge, the vector becomes seconds 00, minutes 00, hours 00, day-of-week 1, date 01, month 01, year 00, with the halt flag, century flag and century enable all 0.
- R2: A tick with the halt flag clear and no load adds one to seconds. Seconds 59 wraps to 00 and adds one to minutes, and minutes 59 wraps to 00 and adds one to hours. All of this happens in the same cycle.
- R3: When hours wraps from 23 to 00, the date and the day of week both advance in that same cycle.
- R4: Day of week counts 1 through 7 and returns from 7 to 1 at each midnight, independently of the date.
- R5: A date at the month's last day wraps to 01 and advances the month. The last day is 30 for months 04, 06, 09 and 11, and 31 for months 01, 03, 05, 07, 08, 10 and 12. An earlier date just advances by one.
- R6: February ends at 29 when the year is divisible by 4, and year 00 counts as such a year. Otherwise February ends at 28.
- R7: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00.
- R8: When year wraps from 99 to 00, the century flag inverts if century enable is 1. If century enable is 0, the century flag keeps its value.
- R9: While the halt flag is 1, ticks change no field.
- R10: In a cycle without tick and without load, no field changes.
- R11: `load` replaces every field with the value on `load_val` at the next edge. If `tick` is also high in that cycle, the load wins and no advance takes place.
- R12: The vector layout is as follows. Bits [6:0] are seconds and bit 7 is the halt flag. Bits [14:8] are minutes. Bits [21:16] are hours. Bits [26:24] are day of week, bit 28 is the century flag and bit 29 is century enable. Bits [37:32] are date. Bits [44:40] are month. Bits [55:48] are year. Every other bit reads as 0, whatever was loaded into it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle pulse, once per second |
| load | input | 1 | Replace all fields with `load_val` |
| load_val | input | 56 | New field values, in the R12 layout |
| time_q | output | 56 | Current field values, in the R12 layout |

## Verification
A load and a tick can arrive in the same cycle. The bench provokes this by raising both `load` and `tick` on one edge with a value one second before midnight. It passes only if the loaded value comes back unchanged, and if the next tick alone then rolls it over to the new day. The halt flag is a second way a tick can be refused. The bench checks it by loading the flag together with a rollover time, pulsing `tick` repeatedly and requiring a frozen vector. The main sweep covers every year from 00 to 99, every month and every candidate last day. Each case is loaded at 23:59:59, ticked once and compared with dates computed arithmetically.

// File: rtl/cal_pkg.sv
// Shared layout of the calendar vector and the state record.
// Assumes all loaded fields hold valid BCD; bits outside the fields are dropped.
package cal_pkg;

    localparam int FIELD_BYTES = 7;
    localparam int VEC_W       = FIELD_BYTES * 8;

    // BCD limits of the fixed-range fields
    localparam logic [7:0] SEC_LAST  = 8'h59;
    localparam logic [7:0] MIN_LAST  = 8'h59;
    localparam logic [7:0] HR_LAST   = 8'h23;
    localparam logic [7:0] MON_LAST  = 8'h12;
    localparam logic [7:0] YEAR_LAST = 8'h99;
    localparam int         DOW_W     = 3;
    localparam int         DOW_LAST  = 7;

    typedef struct packed {
        logic             stop;
        logic [6:0]       sec;
        logic [6:0]       min;
        logic [5:0]       hr;
        logic [DOW_W-1:0] dow;
        logic             cent;
        logic             cent_en;
        logic [5:0]       date;
        logic [4:0]       mon;
        logic [7:0]       year;
    } cal_state_t;

    // Vector to record; reserved bit positions are discarded.
    function automatic cal_state_t unpack_vec(input logic [VEC_W-1:0] v);
        cal_state_t s;
        s.stop    = v[7];
        s.sec     = v[6:0];
        s.min     = v[14:8];
        s.hr      = v[21:16];
        s.dow     = v[26:24];
        s.cent    = v[28];
        s.cent_en = v[29];
        s.date    = v[37:32];
        s.mon     = v[44:40];
        s.year    = v[55:48];
        return s;
    endfunction

    // Record to vector; reserved bit positions read as zero.
    function automatic logic [VEC_W-1:0] pack_vec(input cal_state_t s);
        logic [VEC_W-1:0] v;
        v        = '0;
        v[7]     = s.stop;
        v[6:0]   = s.sec;
        v[14:8]  = s.min;
        v[21:16] = s.hr;
        v[26:24] = s.dow;
        v[28]    = s.cent;
        v[29]    = s.cent_en;
        v[37:32] = s.date;
        v[44:40] = s.mon;
        v[55:48] = s.year;
        return v;
    endfunction

endpackage

// File: rtl/cal_bcd_step.sv
// One field's next-value stage: holds, counts up, or wraps to FIRST when at
// or above LAST. Fields wider than 4 bits count in two-digit BCD; narrower
// fields count in plain binary (values below ten). Combinational only.
module cal_bcd_step #(
    parameter int           W     = 8,
    parameter logic [W-1:0] FIRST = '0
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] last,
    input  logic         adv,
    output logic [W-1:0] nxt,
    output logic         wrap
);
    logic         at_end;
    logic [W-1:0] inc;

    // Reaching the limit decides between wrapping and counting
    assign at_end = (cur >= last);
    assign wrap   = adv & at_end;

    generate
        if (W > 4) begin : g_bcd
            localparam int HI_W = W - 4;
            logic       lo_nine;
            // Units digit rolls 9 -> 0 and carries into the tens digit
            always_comb begin
                lo_nine = (cur[3:0] == 4'd9);
                inc[3:0]   = lo_nine ? 4'd0 : cur[3:0] + 4'd1;
                inc[W-1:4] = cur[W-1:4] + HI_W'(lo_nine);
            end
        end else begin : g_bin
            // Single digit below ten: plain binary increment
            assign inc = cur + W'(1);
        end
    endgenerate

    // Select hold, wrap or increment
    always_comb begin
        if (!adv)        nxt = cur;
        else if (at_end) nxt = FIRST;
        else             nxt = inc;
    end
endmodule

// File: rtl/cal_month_len.sv
// Last valid date of a month, in BCD, worked out from the month and from the
// two year bits that decide divisibility by 4.
// Assumes month is a valid BCD value 01..12.
module cal_month_len (
    input  logic [4:0] mon,
    input  logic       yr_tens_odd,
    input  logic [1:0] yr_units_low,
    output logic [5:0] last_date
);
    logic [1:0] mod4;
    logic       leap;

    // 10*t + u is divisible by 4 exactly when 2*t + u is
    assign mod4 = yr_units_low + {yr_tens_odd, 1'b0};
    assign leap = (mod4 == 2'd0);

    // Month-length table by BCD month code
    always_comb begin
        unique case (mon)
            5'h02:                      last_date = leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: last_date = 6'h30;
            default:                    last_date = 6'h31;
        endcase
    end
endmodule

// File: rtl/cal_bcd_clock.sv
// Top of the BCD calendar counter. Holds all fields in one register record,
// advances on a tick unless halted or loading, and rolls carries through
// every field in one cycle. Assumes tick is a single-cycle pulse.
module cal_bcd_clock
    import cal_pkg::*;
#(
    parameter bit STOP_AT_RESET = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [VEC_W-1:0] load_val,
    output logic [VEC_W-1:0] time_q
);
    cal_state_t st, st_nxt, ld;
    logic       advance;
    logic       c_sec, c_min, c_hr, c_date, c_mon, c_year, c_dow;
    logic [6:0] sec_n, min_n;
    logic [5:0] hr_n, date_n, date_last;
    logic [4:0] mon_n;
    logic [7:0] year_n;
    logic [DOW_W-1:0] dow_n;

    assign ld      = unpack_vec(load_val);
    // A tick counts only when running and not overridden by a load
    assign advance = tick & ~load & ~st.stop;

    cal_bcd_step #(.W(7), .FIRST(7'h00)) u_sec (
        .cur(st.sec), .last(SEC_LAST[6:0]), .adv(advance), .nxt(sec_n), .wrap(c_sec));
    cal_bcd_step #(.W(7), .FIRST(7'h00)) u_min (
        .cur(st.min), .last(MIN_LAST[6:0]), .adv(c_sec), .nxt(min_n), .wrap(c_min));
    cal_bcd_step #(.W(6), .FIRST(6'h00)) u_hr (
        .cur(st.hr), .last(HR_LAST[5:0]), .adv(c_min), .nxt(hr_n), .wrap(c_hr));
    cal_bcd_step #(.W(DOW_W), .FIRST(DOW_W'(1))) u_dow (
        .cur(st.dow), .last(DOW_W'(DOW_LAST)), .adv(c_hr), .nxt(dow_n), .wrap(c_dow));
    cal_month_len u_mlen (
        .mon(st.mon), .yr_tens_odd(st.year[4]), .yr_units_low(st.year[1:0]),
        .last_date(date_last));
    cal_bcd_step #(.W(6), .FIRST(6'h01)) u_date (
        .cur(st.date), .last(date_last), .adv(c_hr), .nxt(date_n), .wrap(c_date));
    cal_bcd_step #(.W(5), .FIRST(5'h01)) u_mon (
        .cur(st.mon), .last(MON_LAST[4:0]), .adv(c_date), .nxt(mon_n), .wrap(c_mon));
    cal_bcd_step #(.W(8), .FIRST(8'h00)) u_year (
        .cur(st.year), .last(YEAR_LAST), .adv(c_mon), .nxt(year_n), .wrap(c_year));

    // Gather the per-field next values; century flips only when enabled
    always_comb begin
        st_nxt      = st;
        st_nxt.sec  = sec_n;
        st_nxt.min  = min_n;
        st_nxt.hr   = hr_n;
        st_nxt.dow  = dow_n;
        st_nxt.date = date_n;
        st_nxt.mon  = mon_n;
        st_nxt.year = year_n;
        st_nxt.cent = st.cent ^ (c_year & st.cent_en);
    end

    // State register: reset, then load over advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= '0;
            st.stop    <= STOP_AT_RESET;
            st.dow     <= DOW_W'(1);
            st.date    <= 6'h01;
            st.mon     <= 5'h01;
        end else if (load) begin
            st <= ld;
        end else begin
            st <= st_nxt;
        end
    end

    assign time_q = pack_vec(st);

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> time_q == pack_vec(unpack_vec($past(load_val)))); // R11
    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && st.stop) |=> $stable(time_q)); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> $stable(time_q)); // R10
    AST_CENT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !st.cent_en) |=> $stable(st.cent)); // R8
    AST_SEC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && st.sec == 7'h59) |=> (st.sec == 7'h00 && st.min != $past(st.min))); // R2
    AST_DOW_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && st.dow != '0) |=> st.dow != '0); // R4
endmodule

// File: tb/sim_cal_bcd_clock.sv
module sim_cal_bcd_clock;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        load = 1'b0;
    logic [55:0] lv = '0;
    logic [55:0] q;
    int checks = 0, fails = 0;
    bit done = 1'b0;
    int e_s, e_m, e_h, e_w, e_d, e_mo, e_y;
    bit e_st, e_c, e_en;

    localparam logic [55:0] RESERVED = 56'h00E0C0C8C08000; // R12

    cal_bcd_clock u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .load(load),
                      .load_val(lv), .time_q(q));

    always #10 clk = ~clk;

    function automatic logic [7:0] b(input int n);
        return 8'(((n / 10) << 4) | (n % 10));
    endfunction

    function automatic int dim(input int mo, input int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [55:0] pk();
        logic [7:0] sb;
        sb = b(e_s);
        return {b(e_y), b(e_mo), b(e_d), {2'b00, e_en, e_c, 1'b0, 3'(e_w)},
                b(e_h), b(e_m), {e_st, sb[6:0]}};
    endfunction

    task automatic set_exp(input int s, m, h, w, d, mo, y, input bit st, c, en);
        e_s = s; e_m = m; e_h = h; e_w = w; e_d = d; e_mo = mo; e_y = y;
        e_st = st; e_c = c; e_en = en;
    endtask

    task automatic model_tick();
        if (!e_st) begin
            e_s++;
            if (e_s == 60) begin
                e_s = 0; e_m++;
                if (e_m == 60) begin
                    e_m = 0; e_h++;
                    if (e_h == 24) begin
                        e_h = 0; e_w = e_w % 7 + 1; e_d++;
                        if (e_d > dim(e_mo, e_y)) begin
                            e_d = 1; e_mo++;
                            if (e_mo == 13) begin
                                e_mo = 1; e_y++;
                                if (e_y == 100) begin
                                    e_y = 0;
                                    if (e_en) e_c = !e_c;
                                end
                            end
                        end
                    end
                end
            end
        end
    endtask

    // All tasks start and end just after a falling edge
    task automatic load_exp();
        lv = pk(); load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic do_tick();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic chk(input string req);
        checks++;
        if (q !== pk()) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, q, pk());
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        set_exp(0, 0, 0, 1, 1, 1, 0, 0, 0, 0);
        chk("R1");
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1");

        // R12: reserved bits are dropped on load and read back as zero
        set_exp(34, 17, 9, 5, 23, 8, 47, 0, 1, 1);
        lv = pk() | RESERVED; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        chk("R12");

        // R2: long run of seconds through minute and hour carries
        set_exp(0, 58, 22, 3, 14, 6, 21, 0, 0, 0);
        load_exp();
        for (int i = 0; i < 3700; i++) begin
            model_tick(); do_tick(); chk("R2");
        end

        // R3 R4: midnight for every day of week, date mid-month
        for (int w = 1; w <= 7; w++) begin
            set_exp(59, 59, 23, w, 10, 3, 5, 0, 0, 0);
            load_exp(); model_tick(); do_tick(); chk("R4");
            if (q[26:24] != 3'(w % 7 + 1) || q[37:32] != 6'h11) begin
                checks++; fails++;
                $display("FAIL R3: got %h expected dow %0d date 11", q, w % 7 + 1);
            end else checks++;
        end

        // R5 R6 R7 R8: every year, month and candidate last day
        for (int y = 0; y < 100; y++)
            for (int mo = 1; mo <= 12; mo++)
                for (int d = 28; d <= 31; d++)
                    if (d <= dim(mo, y)) begin
                        set_exp(59, 59, 23, (y + mo + d) % 7 + 1, d, mo, y, 0, mo % 2, y % 2);
                        load_exp(); model_tick(); do_tick();
                        if (mo == 2) chk("R6");
                        else if (mo == 12 && d == 31) chk(y == 99 ? "R8" : "R7");
                        else chk("R5");
                    end

        // R8: century enable set and clear at the year-99 rollover
        set_exp(59, 59, 23, 7, 31, 12, 99, 0, 0, 1);
        load_exp(); model_tick(); do_tick(); chk("R8");
        set_exp(59, 59, 23, 7, 31, 12, 99, 0, 1, 0);
        load_exp(); model_tick(); do_tick(); chk("R8");

        // R9: halted clock ignores ticks, then resumes
        set_exp(59, 59, 23, 2, 31, 12, 99, 1, 0, 1);
        load_exp();
        for (int i = 0; i < 5; i++) begin
            do_tick(); chk("R9");
        end
        e_st = 0; load_exp(); model_tick(); do_tick(); chk("R9");

        // R10: no tick, no change
        set_exp(12, 34, 5, 6, 7, 8, 9, 0, 1, 0);
        load_exp();
        repeat (6) @(negedge clk);
        chk("R10");

        // R11: load and tick together; load wins, next tick advances
        set_exp(59, 59, 23, 4, 28, 2, 23, 0, 0, 0);
        lv = pk(); load = 1'b1; tick = 1'b1;
        @(negedge clk);
        load = 1'b0; tick = 1'b0;
        chk("R11");
        model_tick(); do_tick(); chk("R11");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule